// File: doc/BRIEF.md
# HDLC Receive Bit Deframer

This block sits behind a line decoder and turns a serial bit stream into HDLC frames delivered as bytes. A bit is taken from `bitIn` on every clock in which `bitEn` is high. The block hunts for the flag pattern 01111110. Inside a frame it deletes the zero that follows five ones. It assembles the remaining bits into bytes, least significant bit first. Each frame is checked against its trailing frame check sequence, which is either the 16-bit CCITT code or the 32-bit code.

Every received bit first passes through an eight-bit raw window. The flag and the run of ones that signals an abort are recognised on that window before its oldest bit becomes data. As a result, the bits of a flag never reach the byte assembler. The last two or four bytes of a frame are its check sequence, so they are held back and stripped. In transparent mode they are passed on like any other byte and no check is made. A single flag may both close a frame and open the next one.

The end of a frame is a one-cycle strobe that carries four status bits: abort, CRC error, short and long. The check type and the transparent option are taken from the control inputs at each flag. The abort threshold depends on `pppMode`.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: A flag (0,1,1,1,1,1,1,0 in line order) that ends a frame holding at least one data bit produces exactly one `outEof` pulse. That flag also opens the next frame, so the bytes that follow it form a new frame without a second flag.
- R2: Inside a frame, a 0 bit that follows five consecutive data 1 bits is discarded. Payload bytes containing long runs of ones are therefore delivered unchanged.
- R3: Data bytes are assembled LSB first from the destuffed bits. With `crcPass`=0, the last 2 bytes (`crcSel`=0) or the last 4 bytes (`crcSel`=1) of a frame are not output. `outSof` marks the first byte output in a frame. `outValid` and `outEof` rise only in the clock after a clock in which `bitEn` was high.
- R4: With `crcSel`=0, CRC-CCITT is used: reflected polynomial 0x8408, preset 0xFFFF, and the frame is good when the register left after the check bytes equals 0xF0B8. A frame with a bad check sets `outCrcErr` with its `outEof`.
- R5: With `crcSel`=1, CRC-32 is used: reflected polynomial 0xEDB88320, preset 0xFFFFFFFF, and the good register value is 0xDEBB20E3. A bad check sets `outCrcErr`.
- R6: With `crcPass`=1, every received byte, the check bytes included, is output, and `outCrcErr` stays 0.
- R7: With `pppMode`=0, a run of 7 ones inside a frame that holds data ends it with `outEof` and `outAbort`, while `outCrcErr`, `outShort` and `outLong` stay low. The line then produces no output until the next flag.
- R8: With `pppMode`=1, a run of 7 to 14 ones ended by a 0 discards the frame without an `outEof`. A run that reaches 15 ones ends the frame with `outEof` and `outAbort`.
- R9: A frame closed by a flag with fewer than 4 received bytes (check bytes included) sets `outShort`, and `outCrcErr` stays 0 for it.
- R10: A frame closed by a flag with more received bytes than `maxLen` (check bytes included) sets `outLong`. Its bytes are still output.
- R11: Flags that enclose no data, and runs of idle ones between frames, produce no output. The four status bits are high only together with `outEof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Line bit is present on `bitIn` this clock |
| bitIn | input | 1 | Serial line bit |
| pppMode | input | 1 | 1: abort after 15 ones; 0: abort after 7 ones |
| crcSel | input | 1 | Check type, taken at each flag: 0 CCITT-16, 1 CRC-32 |
| crcPass | input | 1 | Transparent check bytes, taken at each flag |
| maxLen | input | LEN_W | Largest frame length in bytes that is not long |
| outValid | output | 1 | `outData` carries a frame byte |
| outData | output | 8 | Received byte |
| outSof | output | 1 | First byte output in the frame |
| outEof | output | 1 | Frame end strobe; the status bits are valid with it |
| outAbort | output | 1 | Frame ended by an abort |
| outCrcErr | output | 1 | Check sequence mismatch |
| outShort | output | 1 | Frame shorter than 4 bytes |
| outLong | output | 1 | Frame longer than `maxLen` bytes |

## Verification
A byte leaves the eight-bit window eight line bits after it entered. It appears on the outputs one clock after the `bitEn` of its last bit, or later still while it waits in the check-byte hold. A frame end is signalled one clock after the `bitEn` that completes the closing flag or the abort run. The bench raises `bitEn` for one clock in every three, samples every falling edge, and logs each byte pulse and frame-end pulse. It also records whether `bitEn` was high at the rising edge just before each pulse, so every output is checked against the bit that produced it. Each frame is compared with the arithmetically computed payload and status only after its closing flag has been sent and the pipeline has settled.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam int HOLD_MAX = 4;                 // widest check sequence in bytes
  localparam int HC_W     = $clog2(HOLD_MAX + 1);

  localparam logic [15:0] CCITT_POLY_R = 16'h8408;
  localparam logic [31:0] CRC32_POLY_R = 32'hEDB88320;
  localparam logic [15:0] CCITT_GOOD   = 16'hF0B8;
  localparam logic [31:0] CRC32_GOOD   = 32'hDEBB20E3;

  typedef enum logic [1:0] {
    LINE_HUNT = 2'd0,
    LINE_OPEN = 2'd1,
    LINE_RUN  = 2'd2
  } lineState_t;

  // strobes from line control to byte datapath, valid for one clock
  typedef struct packed {
    logic bitStb;    // a destuffed data bit leaves the window
    logic bitVal;    // its value
    logic flagStb;   // flag completed: close current frame, open next
    logic abortStb;  // abort run reached
    logic dropStb;   // frame discarded silently
  } rxStrobe_t;

  // one byte through a reflected CRC register, LSB first
  function automatic logic [31:0] crcByte(input logic [31:0] cur,
                                          input logic [7:0]  data,
                                          input logic        wide);
    logic [31:0] r;
    logic        fb;
    r = cur;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ data[i];
      if (wide) r = (r >> 1) ^ (fb ? CRC32_POLY_R : 32'h0);
      else      r = {16'h0, (r[15:0] >> 1) ^ (fb ? CCITT_POLY_R : 16'h0)};
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_rx_linectl.sv
module hdlc_rx_linectl
  import hdlc_rx_pkg::*;
#(
  parameter int HDLC_RUN = 7,
  parameter int PPP_RUN  = 15
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitEn,
  input  logic      bitIn,
  input  logic      pppMode,
  output rxStrobe_t stb
);

  localparam int ONES_W = $clog2(PPP_RUN + 1);
  localparam logic [ONES_W-1:0] HDLC_LIM = ONES_W'(HDLC_RUN);
  localparam logic [ONES_W-1:0] PPP_LIM  = ONES_W'(PPP_RUN);

  logic [7:0]        win;      // raw bits, newest at [7]
  logic [7:0]        winVal;   // bit belongs to an open frame
  logic [ONES_W-1:0] onesCnt;  // raw run of ones
  logic [2:0]        dOnes;    // run of ones among exiting data bits
  lineState_t        state;

  logic [7:0]        nWin;
  logic [ONES_W-1:0] nOnes;
  logic              isFlag, stuffed, clearWin;
  lineState_t        nState;

  always_comb begin
    nWin     = {bitIn, win[7:1]};
    nOnes    = bitIn ? ((onesCnt == '1) ? onesCnt : onesCnt + 1'b1) : '0;
    isFlag   = (nWin == 8'h7E);
    stuffed  = !win[0] && (dOnes == 3'd5);
    stb      = '0;
    nState   = state;
    clearWin = 1'b0;
    if (bitEn) begin
      stb.bitStb = winVal[0] && !stuffed;
      stb.bitVal = win[0];
      if (isFlag) begin
        stb.flagStb = 1'b1;
        nState      = LINE_OPEN;
        clearWin    = 1'b1;
      end else begin
        case (state)
          LINE_OPEN: if (nOnes == HDLC_LIM) begin
            clearWin = 1'b1;
            if (pppMode) nState = LINE_RUN;
            else begin
              stb.abortStb = 1'b1;
              nState       = LINE_HUNT;
            end
          end
          LINE_RUN: if (!bitIn) begin
            stb.dropStb = 1'b1;
            nState      = LINE_HUNT;
          end else if (nOnes == PPP_LIM) begin
            stb.abortStb = 1'b1;
            nState       = LINE_HUNT;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      win     <= '0;
      winVal  <= '0;
      onesCnt <= '0;
      dOnes   <= '0;
      state   <= LINE_HUNT;
    end else if (bitEn) begin
      win     <= nWin;
      onesCnt <= nOnes;
      state   <= nState;
      if (clearWin) begin
        winVal <= '0;
        dOnes  <= '0;
      end else begin
        winVal <= {nState == LINE_OPEN, winVal[7:1]};
        if (winVal[0]) begin
          if (stuffed)     dOnes <= '0;
          else if (win[0]) dOnes <= dOnes + 3'd1;
          else             dOnes <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_rx_bytepath.sv
module hdlc_rx_bytepath
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int MIN_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobe_t        stb,
  input  logic             crcSel,
  input  logic             crcPass,
  input  logic [LEN_W-1:0] maxLen,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic             outSof,
  output logic             outEof,
  output logic             outAbort,
  output logic             outCrcErr,
  output logic             outShort,
  output logic             outLong
);

  localparam logic [LEN_W:0] MIN_CNT = (LEN_W + 1)'(MIN_BYTES);

  logic [7:0]      shReg;
  logic [2:0]      bitCnt;
  logic [LEN_W:0]  byteCnt;
  logic            hadData, sofPend, frameC32, framePass;
  logic [7:0]      hold [HOLD_MAX];
  logic [HC_W-1:0] holdCnt;
  logic [31:0]     crcReg;

  logic [HC_W-1:0] crcLen, nHoldCnt;
  logic [7:0]      nSh, emitB;
  logic [7:0]      nHold [HOLD_MAX];
  logic            byteDone, emitV, hadN, crcGood, isShort, isLong;
  logic            closeRep, abortRep, endFrame;
  logic [LEN_W:0]  nByteCnt;
  logic [31:0]     nCrc;

  always_comb begin
    crcLen   = framePass ? HC_W'(0) : (frameC32 ? HC_W'(4) : HC_W'(2));
    nSh      = {stb.bitVal, shReg[7:1]};
    byteDone = stb.bitStb && (bitCnt == 3'd7);
    emitV    = 1'b0;
    emitB    = nSh;
    nHold    = hold;
    nHoldCnt = holdCnt;
    if (byteDone) begin
      if (crcLen == '0) begin
        emitV = 1'b1;
      end else if (holdCnt < crcLen) begin
        for (int i = 0; i < HOLD_MAX; i++)
          if (HC_W'(i) == holdCnt) nHold[i] = nSh;
        nHoldCnt = holdCnt + 1'b1;
      end else begin
        emitV = 1'b1;
        emitB = hold[0];
        for (int i = 0; i < HOLD_MAX - 1; i++)
          if (HC_W'(i + 1) < crcLen) nHold[i] = hold[i + 1];
        for (int i = 0; i < HOLD_MAX; i++)
          if (HC_W'(i) == crcLen - 1'b1) nHold[i] = nSh;
      end
    end
    nByteCnt = (byteDone && byteCnt != '1) ? byteCnt + 1'b1 : byteCnt;
    nCrc     = byteDone ? crcByte(crcReg, nSh, frameC32) : crcReg;
    crcGood  = frameC32 ? (nCrc == CRC32_GOOD) : (nCrc[15:0] == CCITT_GOOD);
    isShort  = nByteCnt < MIN_CNT;
    isLong   = nByteCnt > {1'b0, maxLen};
    hadN     = hadData || stb.bitStb;
    closeRep = stb.flagStb && hadN;
    abortRep = stb.abortStb && hadN;
    endFrame = stb.flagStb || stb.abortStb || stb.dropStb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      outSof    <= 1'b0;
      outEof    <= 1'b0;
      outAbort  <= 1'b0;
      outCrcErr <= 1'b0;
      outShort  <= 1'b0;
      outLong   <= 1'b0;
      shReg     <= '0;
      bitCnt    <= '0;
      byteCnt   <= '0;
      hadData   <= 1'b0;
      sofPend   <= 1'b1;
      holdCnt   <= '0;
      crcReg    <= '1;
      frameC32  <= 1'b0;
      framePass <= 1'b0;
      for (int i = 0; i < HOLD_MAX; i++) hold[i] <= '0;
    end else begin
      outValid  <= emitV;
      outData   <= emitB;
      outSof    <= emitV && sofPend;
      outEof    <= closeRep || abortRep;
      outAbort  <= abortRep;
      outCrcErr <= closeRep && !framePass && !isShort && !crcGood;
      outShort  <= closeRep && isShort;
      outLong   <= closeRep && isLong;
      if (endFrame) begin
        bitCnt  <= '0;
        byteCnt <= '0;
        hadData <= 1'b0;
        sofPend <= 1'b1;
        holdCnt <= '0;
        crcReg  <= '1;
        if (stb.flagStb) begin
          frameC32  <= crcSel;
          framePass <= crcPass;
        end
      end else begin
        if (stb.bitStb) begin
          shReg  <= nSh;
          bitCnt <= bitCnt + 3'd1;
        end
        byteCnt <= nByteCnt;
        hadData <= hadN;
        holdCnt <= nHoldCnt;
        crcReg  <= nCrc;
        hold    <= nHold;
        if (emitV) sofPend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int MIN_BYTES = 4,
  parameter int HDLC_RUN  = 7,
  parameter int PPP_RUN   = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             bitIn,
  input  logic             pppMode,
  input  logic             crcSel,
  input  logic             crcPass,
  input  logic [LEN_W-1:0] maxLen,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic             outSof,
  output logic             outEof,
  output logic             outAbort,
  output logic             outCrcErr,
  output logic             outShort,
  output logic             outLong
);

  rxStrobe_t stb;

  hdlc_rx_linectl #(
    .HDLC_RUN (HDLC_RUN),
    .PPP_RUN  (PPP_RUN)
  ) u_line (
    .clk     (clk),
    .rstN    (rstN),
    .bitEn   (bitEn),
    .bitIn   (bitIn),
    .pppMode (pppMode),
    .stb     (stb)
  );

  hdlc_rx_bytepath #(
    .LEN_W     (LEN_W),
    .MIN_BYTES (MIN_BYTES)
  ) u_bytes (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .crcSel    (crcSel),
    .crcPass   (crcPass),
    .maxLen    (maxLen),
    .outValid  (outValid),
    .outData   (outData),
    .outSof    (outSof),
    .outEof    (outEof),
    .outAbort  (outAbort),
    .outCrcErr (outCrcErr),
    .outShort  (outShort),
    .outLong   (outLong)
  );

endmodule

// File: rtl/hdlc_rx_checker.sv
module hdlc_rx_checker (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic outValid,
  input logic outSof,
  input logic outEof,
  input logic outAbort,
  input logic outCrcErr,
  input logic outShort,
  input logic outLong
);

  // R11
  status_needs_eof_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outEof |-> !(outAbort || outCrcErr || outShort || outLong));

  // R7
  abort_alone_chk: assert property (@(posedge clk) disable iff (!rstN)
    outAbort |-> (!outCrcErr && !outShort && !outLong));

  // R9
  short_no_crc_chk: assert property (@(posedge clk) disable iff (!rstN)
    outShort |-> !outCrcErr);

  // R3
  sof_with_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> outValid);

  // R3
  out_after_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid || outEof) |-> $past(bitEn));

  // R1
  eof_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEof |=> !outEof);

endmodule

bind hdlc_rx_deframer hdlc_rx_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitEn     (bitEn),
  .outValid  (outValid),
  .outSof    (outSof),
  .outEof    (outEof),
  .outAbort  (outAbort),
  .outCrcErr (outCrcErr),
  .outShort  (outShort),
  .outLong   (outLong)
);

// File: tb/tb_hdlc_rx_deframer.sv
module tb_hdlc_rx_deframer;

  localparam int LEN_W = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             bitEn = 1'b0;
  logic             bitIn = 1'b1;
  logic             pppMode = 1'b0;
  logic             crcSel = 1'b0;
  logic             crcPass = 1'b0;
  logic [LEN_W-1:0] maxLen = 12'd8;
  logic             outValid, outSof, outEof, outAbort, outCrcErr, outShort, outLong;
  logic [7:0]       outData;

  always #4 clk = ~clk;  // 125 MHz

  hdlc_rx_deframer dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .bitIn(bitIn), .pppMode(pppMode),
    .crcSel(crcSel), .crcPass(crcPass), .maxLen(maxLen),
    .outValid(outValid), .outData(outData), .outSof(outSof), .outEof(outEof),
    .outAbort(outAbort), .outCrcErr(outCrcErr), .outShort(outShort), .outLong(outLong)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // monitor state
  logic [7:0] rxData [64];
  bit         rxSof  [64];
  int         rxN = 0;
  int         eofN = 0;
  logic [3:0] eofSt = '0;
  int         strayCnt = 0;
  int         lateCnt = 0;
  logic       bitEnQ = 1'b0;

  logic [7:0] txBuf [64];
  logic [7:0] expB  [64];
  int         txOnes = 0;

  always @(posedge clk) bitEnQ <= bitEn;

  always @(negedge clk) if (rstN) begin
    if ((outValid || outEof) && !bitEnQ) lateCnt++;
    if (!outEof && (outAbort || outCrcErr || outShort || outLong)) strayCnt++;
    if (outValid && rxN < 64) begin
      rxData[rxN] = outData;
      rxSof[rxN]  = outSof;
      rxN++;
    end
    if (outEof) begin
      eofN++;
      eofSt = {outAbort, outCrcErr, outShort, outLong};
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic clearRx();
    rxN = 0;
    eofN = 0;
    eofSt = '0;
  endtask

  task automatic sendBit(input bit b);
    @(negedge clk);
    bitIn = b;
    bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendFlag();
    sendBit(1'b0);
    for (int i = 0; i < 6; i++) sendBit(1'b1);
    sendBit(1'b0);
    txOnes = 0;
  endtask

  task automatic sendOnes(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b1);
    txOnes = 0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      sendBit(v[i]);
      if (v[i]) txOnes++;
      else txOnes = 0;
      if (txOnes == 5) begin
        sendBit(1'b0);
        txOnes = 0;
      end
    end
  endtask

  // transmitter-side FCS: complemented register, LSB first on the line
  function automatic logic [31:0] genFcs(input int n, input bit wide);
    logic [31:0] r;
    logic        fb;
    r = wide ? 32'hFFFFFFFF : 32'h0000FFFF;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        fb = r[0] ^ txBuf[k][i];
        if (wide) r = (r >> 1) ^ (fb ? 32'hEDB88320 : 32'h0);
        else      r = ((r >> 1) ^ (fb ? 32'h00008408 : 32'h0)) & 32'h0000FFFF;
      end
    return wide ? ~r : (~r & 32'h0000FFFF);
  endfunction

  task automatic sendFrame(input int n, input bit wide, input bit openFlag, input bit corrupt);
    logic [31:0] fcs;
    int          nf;
    nf  = wide ? 4 : 2;
    fcs = genFcs(n, wide);
    for (int k = 0; k < nf; k++) txBuf[n + k] = fcs[8*k +: 8];
    if (corrupt) txBuf[n] = txBuf[n] ^ 8'h01;
    if (openFlag) sendFlag();
    for (int k = 0; k < n + nf; k++) sendByte(txBuf[k]);
    sendFlag();
    repeat (4) @(negedge clk);
  endtask

  task automatic checkFrame(input string tag, input int expN, input int expEof, input logic [3:0] expSt);
    bit okB, okS;
    okB = 1'b1;
    okS = 1'b1;
    chk(rxN == expN, {tag, " R3 byte count"}, rxN, expN);
    for (int i = 0; i < expN && i < rxN; i++) begin
      if (rxData[i] !== expB[i]) okB = 1'b0;
      if (rxSof[i] !== (i == 0)) okS = 1'b0;
    end
    if (expN > 0) begin
      chk(okB, {tag, " R3 R2 byte values"}, rxData[0], expB[0]);
      chk(okS, {tag, " R3 sof marking"}, rxSof[0], 1);
    end
    chk(eofN == expEof, {tag, " R1 eof count"}, eofN, expEof);
    if (expEof > 0) chk(eofSt == expSt, {tag, " R9 R10 status {abort,crc,short,long}"}, eofSt, expSt);
    clearRx();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int total, expN, nf;
    logic [3:0] st;
    string tag;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid && !outEof && !outSof && !outAbort && !outCrcErr && !outShort && !outLong,
        "R11 reset state", {outValid, outEof}, 0);

    // idle line and empty flags: nothing out
    sendOnes(16);
    sendFlag();
    sendFlag();
    sendFlag();
    sendOnes(10);
    repeat (4) @(negedge clk);
    checkFrame("R11 idle flags", 0, 0, 4'b0000);

    // sweep: mode 0 ccitt, 1 crc32, 2 transparent ccitt; two patterns; lengths 0..7
    for (int mode = 0; mode < 3; mode++)
      for (int p = 0; p < 2; p++)
        for (int len = 0; len < 8; len++) begin
          crcSel  = (mode == 1);
          crcPass = (mode == 2);
          for (int i = 0; i < len; i++)
            txBuf[i] = (p == 1) ? ((i % 3 == 2) ? 8'h7E : 8'hFF) : 8'((i * 73 + len * 29 + mode * 5) & 255);
          sendFrame(len, mode == 1, 1'b1, 1'b0);
          nf    = (mode == 1) ? 4 : 2;
          total = len + nf;
          expN  = (mode == 2) ? total : len;
          for (int i = 0; i < expN; i++) expB[i] = txBuf[i];
          st = {1'b0, 1'b0, total < 4, total > 8};
          case (mode)
            0: tag = "R4";
            1: tag = "R5";
            default: tag = "R6";
          endcase
          checkFrame($sformatf("%s%s len%0d", tag, (p == 1) ? " R2" : "", len), expN, 1, st);
        end

    // corrupted check sequences
    for (int w = 0; w < 2; w++) begin
      crcSel  = w[0];
      crcPass = 1'b0;
      for (int i = 0; i < 3; i++) txBuf[i] = 8'(8'h31 + i * 17);
      sendFrame(3, w[0], 1'b1, 1'b1);
      for (int i = 0; i < 3; i++) expB[i] = txBuf[i];
      checkFrame(w == 0 ? "R4 bad fcs" : "R5 bad fcs", 3, 1, {1'b0, 1'b1, 1'b0, (3 + (w ? 4 : 2)) > 8});
    end

    // shared flag: second frame needs no opening flag
    crcSel  = 1'b0;
    crcPass = 1'b0;
    for (int i = 0; i < 3; i++) txBuf[i] = 8'(8'hA0 + i);
    sendFrame(3, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) expB[i] = txBuf[i];
    checkFrame("R1 frame A", 3, 1, 4'b0000);
    for (int i = 0; i < 4; i++) txBuf[i] = 8'(8'h5C + i * 3);
    sendFrame(4, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) expB[i] = txBuf[i];
    checkFrame("R1 shared flag frame B", 4, 1, 4'b0000);

    // plain mode abort, transparent so bytes are visible
    crcPass = 1'b1;
    sendOnes(8);
    sendFlag();
    sendByte(8'hA1); sendByte(8'hB2); sendByte(8'hC3); sendByte(8'h00);
    sendOnes(7);
    repeat (4) @(negedge clk);
    expB[0] = 8'hA1; expB[1] = 8'hB2; expB[2] = 8'hC3;
    checkFrame("R7 abort", 3, 1, 4'b1000);
    sendByte(8'h55); sendByte(8'hAA); sendByte(8'h12); sendByte(8'h34);
    repeat (4) @(negedge clk);
    checkFrame("R7 hunt after abort", 0, 0, 4'b0000);

    // ppp mode: 10 ones then 0 drops silently; 15 ones aborts
    pppMode = 1'b1;
    sendOnes(8);
    sendFlag();
    sendByte(8'hA1); sendByte(8'hB2); sendByte(8'hC3); sendByte(8'h00);
    sendOnes(10);
    sendBit(1'b0);
    repeat (4) @(negedge clk);
    checkFrame("R8 ppp run of 10", 3, 0, 4'b0000);
    sendFlag();
    sendByte(8'hA1); sendByte(8'hB2); sendByte(8'hC3); sendByte(8'h00);
    sendOnes(15);
    repeat (4) @(negedge clk);
    checkFrame("R8 ppp abort at 15", 3, 1, 4'b1000);
    crcPass = 1'b0;
    crcSel  = 1'b1;
    for (int i = 0; i < 5; i++) txBuf[i] = 8'(8'hF0 ^ (i * 9));
    sendFrame(5, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) expB[i] = txBuf[i];
    checkFrame("R8 ppp good frame", 5, 1, 4'b0001);
    pppMode = 1'b0;

    // long boundary with a larger limit
    maxLen  = 12'd9;
    crcSel  = 1'b0;
    for (int i = 0; i < 7; i++) txBuf[i] = 8'(i * 11);
    sendFrame(7, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 7; i++) expB[i] = txBuf[i];
    checkFrame("R10 length equal to limit", 7, 1, 4'b0000);
    maxLen  = 12'd8;

    chk(strayCnt == 0, "R11 status without eof", strayCnt, 0);
    chk(lateCnt == 0, "R3 output not one clock after bitEn", lateCnt, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule